// File: doc/BRIEF.md
# Five-Word Coefficient and Control Loader

This block turns a serial stream of 12-bit configuration words into single-cycle write strobes for a filter's coefficient banks and its round and limit register files. It runs on the load clock and takes one word per rising edge while the active-low load enable is held low. Each transfer is five words long. The first word is a target address. The next four are payload, and they are held inside the loader until the transfer is complete.

The write strobe rises in the same cycle the fifth word is presented. The receiving file therefore commits the value on the edge that captures that word. Transfers may follow one another with the enable kept low. A new session is armed only when the enable falls from high to low. Raising the enable part-way through a transfer throws the partial transfer away.

Top module: `cfg_word_loader`

## Requirements
- R1: A word is taken only on a rising clock edge at which `load_n` is low. Words presented while `load_n` is high have no effect on any strobe or on any later transfer.
- R2: Loading is armed only by a high-to-low change of `load_n` that is seen after reset. If `load_n` stays low from reset onward, no word is taken and no strobe is raised.
- R3: An address in 000h–0FFh selects a coefficient set. `coef_we` pulses with `coef_row` equal to address bits 7:0. Bank k (k = 0..3) reads `coef_data[12k+11:12k]`, which carries payload word k+1 unchanged.
- R4: An address in 800h–80Fh selects round register address[3:0]. `rnd_we` pulses and `reg_idx` equals that index. `reg_data` is built from the low bytes of payload words 1 to 4, least significant byte first. Bits 11:8 of those words are ignored.
- R5: An address in C00h–C0Fh selects limit register address[3:0]. `lmt_we` pulses. `reg_data[15:0]` is the lower bound, formed from the low bytes of payload words 1 (low) and 2 (high). `reg_data[31:16]` is the upper bound, formed from payload words 3 (low) and 4 (high).
- R6: A strobe is high only in the cycle in which the fifth word of a transfer is presented, and only for that one cycle. No strobe is high while the address word or payload words 1 to 3 are presented.
- R7: The word that follows a completed transfer, with `load_n` still low, is decoded as a new address.
- R8: Raising `load_n` before the fifth word discards the partial transfer without any strobe. The next armed session starts again from an address word.
- R9: An address outside the three ranges still takes its four payload words but raises no strobe. The word after them is a new address.
- R10: At most one of `coef_we`, `rnd_we` and `lmt_we` is high in any cycle.
- R11: While `rst_n` is low, all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Load clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Load enable, active low |
| cfg_word | input | 12 | Serial configuration word |
| coef_we | output | 1 | Coefficient set write strobe |
| coef_row | output | 8 | Coefficient set index |
| coef_data | output | 48 | Four bank coefficients, bank 0 in the low lane |
| rnd_we | output | 1 | Round register write strobe |
| lmt_we | output | 1 | Limit register write strobe |
| reg_idx | output | 4 | Round or limit register index |
| reg_data | output | 32 | Packed round value, or upper:lower limit pair |

## Verification
The tests cover each of the three target spaces with payloads chosen to expose specific faults. Distinct values in every lane reveal swapped banks or swapped bytes. Setting the ignored nibble to ones reveals faulty byte packing on the register paths. Transfers sent back to back, with an invalid address between two valid ones, show whether the word counter re-aligns on address words. A transfer abandoned midway and an enable held low since reset show whether arming depends on the falling transition and not on the enable level. Noise on the word input while the enable is high confirms that nothing is taken at those edges.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_COEF = 2'd1,
        TGT_RND  = 2'd2,
        TGT_LMT  = 2'd3
    } tgt_e;
endpackage

// File: rtl/cwl_framer.sv
// Sequences address + payload words and raises fire_o while the last word is presented.
module cwl_framer #(
    parameter int WORD_W   = 12,
    parameter int NUM_DATA = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_n,
    input  logic [WORD_W-1:0]            word_in,
    output logic [WORD_W-1:0]            addr_o,
    output logic [NUM_DATA*WORD_W-1:0]   data_o,
    output logic                         fire_o
);
    localparam int CNT_W  = $clog2(NUM_DATA + 1);
    localparam int HOLD_W = (NUM_DATA - 1) * WORD_W;

    typedef struct packed {
        logic              prev_hi;
        logic              armed;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] addr;
        logic [HOLD_W-1:0] hold;
    } st_t;

    st_t st_d, st_q;
    logic take;

    always_comb begin
        st_d         = st_q;
        st_d.prev_hi = load_n;
        take         = !load_n && (st_q.armed || st_q.prev_hi);
        fire_o       = take && (st_q.cnt == CNT_W'(NUM_DATA));
        if (load_n) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (take) begin
            st_d.armed = 1'b1;
            if (st_q.cnt == '0) begin
                st_d.addr = word_in;
                st_d.cnt  = CNT_W'(1);
            end else if (fire_o) begin
                st_d.cnt = '0;
            end else begin
                for (int k = 0; k < NUM_DATA - 1; k++) begin
                    if (st_q.cnt == CNT_W'(k + 1))
                        st_d.hold[k*WORD_W +: WORD_W] = word_in;
                end
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign data_o = {word_in, st_q.hold};
endmodule

// File: rtl/cwl_decode.sv
// Classifies the held address word into one of the target spaces.
module cwl_decode
    import cwl_pkg::*;
#(
    parameter int           WORD_W   = 12,
    parameter int           ROW_W    = 8,
    parameter int           IDX_W    = 4,
    parameter logic [11:0]  RND_BASE = 12'h800,
    parameter logic [11:0]  LMT_BASE = 12'hC00
) (
    input  logic [WORD_W-1:0] addr,
    output tgt_e              kind
);
    localparam int HI_COEF = WORD_W - ROW_W;
    localparam int HI_REG  = WORD_W - IDX_W;
    localparam logic [HI_REG-1:0] RND_TAG = RND_BASE[WORD_W-1:IDX_W];
    localparam logic [HI_REG-1:0] LMT_TAG = LMT_BASE[WORD_W-1:IDX_W];

    always_comb begin
        if (addr[WORD_W-1 -: HI_COEF] == '0)      kind = TGT_COEF;
        else if (addr[WORD_W-1:IDX_W] == RND_TAG) kind = TGT_RND;
        else if (addr[WORD_W-1:IDX_W] == LMT_TAG) kind = TGT_LMT;
        else                                      kind = TGT_NONE;
    end
endmodule

// File: rtl/cwl_pack.sv
// Lays payload words onto the coefficient lanes and the byte-packed register word.
module cwl_pack #(
    parameter int WORD_W   = 12,
    parameter int NUM_DATA = 4,
    parameter int REG_W    = 32
) (
    input  logic [NUM_DATA*WORD_W-1:0] data,
    output logic [NUM_DATA*WORD_W-1:0] coef_data,
    output logic [REG_W-1:0]           reg_data
);
    localparam int LANE_W = REG_W / NUM_DATA;

    for (genvar k = 0; k < NUM_DATA; k++) begin : g_lane
        assign coef_data[k*WORD_W +: WORD_W] = data[k*WORD_W +: WORD_W];
        assign reg_data[k*LANE_W +: LANE_W]  = data[k*WORD_W +: LANE_W];
    end
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
    import cwl_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int NUM_DATA = 4,
    parameter int ROW_W    = 8,
    parameter int IDX_W    = 4,
    parameter int REG_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_n,
    input  logic [WORD_W-1:0]          cfg_word,
    output logic                       coef_we,
    output logic [ROW_W-1:0]           coef_row,
    output logic [NUM_DATA*WORD_W-1:0] coef_data,
    output logic                       rnd_we,
    output logic                       lmt_we,
    output logic [IDX_W-1:0]           reg_idx,
    output logic [REG_W-1:0]           reg_data
);
    logic [WORD_W-1:0]          addr;
    logic [NUM_DATA*WORD_W-1:0] payload;
    logic                       fire;
    tgt_e                       kind;

    cwl_framer #(.WORD_W(WORD_W), .NUM_DATA(NUM_DATA)) u_framer (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .word_in(cfg_word),
        .addr_o(addr), .data_o(payload), .fire_o(fire)
    );

    cwl_decode #(.WORD_W(WORD_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_decode (
        .addr(addr), .kind(kind)
    );

    cwl_pack #(.WORD_W(WORD_W), .NUM_DATA(NUM_DATA), .REG_W(REG_W)) u_pack (
        .data(payload), .coef_data(coef_data), .reg_data(reg_data)
    );

    assign coef_we  = fire && (kind == TGT_COEF);
    assign rnd_we   = fire && (kind == TGT_RND);
    assign lmt_we   = fire && (kind == TGT_LMT);
    assign coef_row = addr[ROW_W-1:0];
    assign reg_idx  = addr[IDX_W-1:0];
endmodule

// File: rtl/cwl_loader_chk.sv
module cwl_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic load_n,
    input logic coef_we,
    input logic rnd_we,
    input logic lmt_we
);
    logic       any_we;
    logic [2:0] run_q;   // consecutive prior edges with load_n low, saturating

    assign any_we = coef_we | rnd_we | lmt_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_q <= '0;
        else if (load_n)      run_q <= '0;
        else if (run_q != 3'd7) run_q <= run_q + 3'd1;
    end

    p_single_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({coef_we, rnd_we, lmt_we}));

    p_strobe_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any_we |-> !load_n);

    p_strobe_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_we |=> !any_we);

    p_strobe_after_full_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_we |-> (run_q >= 3'd4));

    always @(negedge clk) begin
        if (!rst_n) p_reset_quiet_r11: assert (!any_we);
    end
endmodule

bind cfg_word_loader cwl_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load_n(load_n),
    .coef_we(coef_we), .rnd_we(rnd_we), .lmt_we(lmt_we)
);

// File: tb/cfg_word_loader_bench.sv
module cfg_word_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_n = 1'b0;
    logic [11:0] cfg_word = '0;
    logic        coef_we, rnd_we, lmt_we;
    logic [7:0]  coef_row;
    logic [47:0] coef_data;
    logic [3:0]  reg_idx;
    logic [31:0] reg_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    cfg_word_loader u_cfg_word_loader (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cfg_word(cfg_word),
        .coef_we(coef_we), .coef_row(coef_row), .coef_data(coef_data),
        .rnd_we(rnd_we), .lmt_we(lmt_we), .reg_idx(reg_idx), .reg_data(reg_data)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] strobes();
        return {coef_we, rnd_we, lmt_we};
    endfunction

    task automatic send_word(input logic [11:0] w);
        @(negedge clk);
        load_n   = 1'b0;
        cfg_word = w;
        #2;
    endtask

    task automatic idle(input int n, input logic [11:0] noise);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            load_n   = 1'b1;
            cfg_word = noise ^ 12'(i);
            #2;
            check("R1", "strobes with enable high", 64'(strobes()), 64'd0);
        end
    endtask

    // Sends one full transfer and checks strobes, index and data at the fifth word.
    task automatic run_burst(input string req, input logic [11:0] a,
                             input logic [11:0] d1, input logic [11:0] d2,
                             input logic [11:0] d3, input logic [11:0] d4);
        logic [2:0]  exp_we;
        logic [31:0] exp_reg;
        if (a[11:8] == 4'h0)       exp_we = 3'b100;
        else if (a[11:4] == 8'h80) exp_we = 3'b010;
        else if (a[11:4] == 8'hC0) exp_we = 3'b001;
        else                       exp_we = 3'b000;
        exp_reg = {d4[7:0], d3[7:0], d2[7:0], d1[7:0]};
        send_word(a);
        check("R6", "strobes at address word", 64'(strobes()), 64'd0);
        send_word(d1);
        check("R6", "strobes at payload 1", 64'(strobes()), 64'd0);
        send_word(d2);
        check("R6", "strobes at payload 2", 64'(strobes()), 64'd0);
        send_word(d3);
        check("R6", "strobes at payload 3", 64'(strobes()), 64'd0);
        send_word(d4);
        check(req, "strobes at payload 4", 64'(strobes()), 64'(exp_we));
        check("R10", "at most one strobe", 64'($countones(strobes()) <= 1), 64'd1);
        if (exp_we == 3'b100) begin
            check("R3", "coef_row", 64'(coef_row), 64'(a[7:0]));
            check("R3", "coef_data", 64'(coef_data), 64'({d4, d3, d2, d1}));
        end else if (exp_we != 3'b000) begin
            check(req, "reg_idx", 64'(reg_idx), 64'(a[3:0]));
            check(req, "reg_data", 64'(reg_data), 64'(exp_reg));
        end
    endtask

    task automatic t_reset_and_arming();
        load_n = 1'b0;
        repeat (3) @(negedge clk);
        #2 check("R11", "strobes in reset", 64'(strobes()), 64'd0);
        @(negedge clk) rst_n = 1'b1;
        // enable low since reset: nothing is taken
        send_word(12'h001);
        for (int i = 0; i < 5; i++) begin
            send_word(12'h100 + 12'(i));
            check("R2", "strobes without arming edge", 64'(strobes()), 64'd0);
        end
        idle(2, 12'h0F0);
    endtask

    task automatic t_coef();
        run_burst("R3", 12'h00A, 12'hABC, 12'h789, 12'h456, 12'h123);
    endtask

    task automatic t_round();
        run_burst("R4", 12'h80A, 12'hF10, 12'hF32, 12'hF54, 12'hF76);
        check("R4", "round value with reserved nibbles set", 64'(reg_data), 64'h7654_3210);
    endtask

    task automatic t_limit();
        run_burst("R5", 12'hC0F, 12'h023, 12'h001, 12'h0ED, 12'h07F);
        check("R5", "lower bound", 64'(reg_data[15:0]), 64'h0123);
        check("R5", "upper bound", 64'(reg_data[31:16]), 64'h7FED);
    endtask

    task automatic t_back_to_back();
        idle(1, 12'h800);
        run_burst("R7", 12'h0FF, 12'h001, 12'h802, 12'hC03, 12'hFFF);
        run_burst("R7", 12'h800, 12'h0AA, 12'h0BB, 12'h0CC, 12'h0DD);
        run_burst("R7", 12'hC00, 12'h000, 12'h080, 12'hFFF, 12'h07F);
    endtask

    task automatic t_noise_while_high();
        idle(4, 12'hC05);
        run_burst("R1", 12'h033, 12'h111, 12'h222, 12'h333, 12'h444);
    endtask

    task automatic t_abandon();
        idle(1, 12'h000);
        send_word(12'h005);
        send_word(12'h111);
        send_word(12'h222);
        send_word(12'h333);
        check("R8", "strobes before abandon", 64'(strobes()), 64'd0);
        idle(1, 12'h444);
        check("R8", "strobes at abandon", 64'(strobes()), 64'd0);
        run_burst("R8", 12'h006, 12'h5A5, 12'hA5A, 12'h0F0, 12'hF0F);
    endtask

    task automatic t_invalid();
        idle(1, 12'h000);
        run_burst("R9", 12'h400, 12'h80F, 12'hC0F, 12'h001, 12'h002);
        run_burst("R9", 12'h803, 12'h001, 12'h002, 12'h003, 12'h004);
        run_burst("R9", 12'hC10, 12'h000, 12'h000, 12'h000, 12'h000);
        run_burst("R9", 12'hC01, 12'h0FF, 12'h000, 12'h0FF, 12'h000);
    endtask

    initial begin
        t_reset_and_arming();
        t_coef();
        t_round();
        t_limit();
        t_back_to_back();
        t_noise_while_high();
        t_abandon();
        t_invalid();
        idle(2, 12'h000);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule